// File: doc/BRIEF.md
# Synthesizer Divider and Phase Comparator

This block is the digital half of an integer-N frequency synthesizer. It holds two programmable counters and a phase-frequency comparator. The main counter advances on strobes taken from the halved oscillator signal, and its division ratio is a fixed offset of 2304 plus an 8-bit code. The reference counter advances on strobes taken from a 12 or 13 MHz reference, and it divides by 12 or 13. Either setting yields a 1 MHz comparison rate. Each counter emits a single-cycle terminal-count pulse. The comparator turns the relative arrival of those pulses into "pump up" and "pump down" pulses for an external charge pump.

Both input signals reach the block as one-cycle strobes in a single system clock domain. Each strobe marks one edge of its source. This keeps every register on one clock. The time resolution of the comparator is one system clock cycle. The charge pump, loop filter and oscillator lie outside the block. As examples of the ratio encoding, code 98 gives 2402 and code 177 gives 2481. An odd code one above an even transmit code lands 1 MHz higher, on the matching receive channel.

Top module: `synth_div_pfd`

## Requirements
- R1: The main counter divides by 2304 + `main_code`, where the code is unsigned with bit 7 as its MSB. This gives ratios 2304 to 2559 system-cycle strobes between `main_tc` pulses.
- R2: The reference counter divides by 13 when `ref_sel` is 2'b10 or 2'b11, and by 12 when it is 2'b00 or 2'b01. Bit 0 has no effect.
- R3: Each counter advances only in cycles where its own strobe (`lo_tick` or `ref_tick`) is high. A strobe of the other counter has no effect on it.
- R4: A changed code is taken up only at a terminal count. The interval already running finishes with the ratio captured at the previous terminal count.
- R5: A terminal-count pulse is high for exactly one cycle. It appears in the cycle after the posedge that takes in the completing strobe.
- R6: The first output to rise follows the leading counter. An earlier `ref_tc` raises `pump_up` and an earlier `main_tc` raises `pump_dn`, each one cycle after its pulse.
- R7: Let d be the number of cycles between the two terminal-count pulses. The leading pump output stays high for d + 1 cycles and the lagging one for 1 cycle. Both are high together for exactly one cycle and are both low in the next.
- R8: Coincident terminal-count pulses raise both pump outputs for one single cycle.
- R9: While `en` is low, both counters are cleared and all four outputs are low from the next cycle on. After `en` rises, each counter counts its first strobe as strobe 1.
- R10: With `rst` high at a clock edge, all outputs are low after that edge (synchronous, active-high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Synthesizer enable; low holds everything cleared |
| lo_tick | input | 1 | One-cycle strobe per edge of the halved oscillator signal |
| ref_tick | input | 1 | One-cycle strobe per edge of the reference signal |
| main_code | input | 8 | Main ratio code n, ratio = 2304 + n |
| ref_sel | input | 2 | Reference ratio select (bit 1 picks 13) |
| main_tc | output | 1 | Main counter terminal-count pulse |
| ref_tc | output | 1 | Reference counter terminal-count pulse |
| pump_up | output | 1 | Source request, raised when the reference leads |
| pump_dn | output | 1 | Sink request, raised when the main counter leads |

## Verification
A terminal-count pulse is due one cycle after the posedge that takes in the completing strobe. A pump output is due one cycle after that, and the overlap clear comes one cycle later still. The bench drives all inputs and samples all outputs at falling edges, so each expected value can be tied to a falling-edge count. Ratio checks count falling edges between successive pulses. Phase checks place the twelfth reference strobe a chosen number of cycles before or after the main counter's last strobe, then compare the rise times and high-cycle counts of both pump outputs with that offset.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

  // Registered comparator state: one flag per charge-pump direction.
  typedef struct packed {
    logic up;
    logic dn;
  } pump_t;

  localparam pump_t PUMP_IDLE = '{up: 1'b0, dn: 1'b0};

endpackage

// File: rtl/prog_divider.sv
module prog_divider #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] ratio,
  output logic             tc
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ratio_q;
  logic             last;

  assign last = (cnt == ratio_q - 1'b1);

  // Ratio is captured while idle and again at every terminal count only.
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt     <= '0;
      ratio_q <= ratio;
      tc      <= 1'b0;
    end else begin
      tc <= 1'b0;
      if (tick) begin
        if (last) begin
          cnt     <= '0;
          ratio_q <= ratio;
          tc      <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R5: a terminal pulse never lasts two cycles (ratios are at least 2)
  p_tc_single_r5: assert property (@(posedge clk) disable iff (rst)
    tc |=> !tc);

  // R1: the count stays below the captured ratio
  p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (rst)
    cnt < ratio_q);

  // R9: disabled counter emits nothing
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> !tc);

  // R3: without a strobe the counter value holds
  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !$past(tick)) |-> $stable(cnt));

endmodule

// File: rtl/phase_freq_cmp.sv
module phase_freq_cmp
  import synth_div_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ref_tc,
  input  logic main_tc,
  output logic pump_up,
  output logic pump_dn
);

  pump_t q;

  // Overlap clears both flags; that clear wins over any new pulse.
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      q <= PUMP_IDLE;
    end else if (q.up && q.dn) begin
      q <= PUMP_IDLE;
    end else begin
      q.up <= q.up | ref_tc;
      q.dn <= q.dn | main_tc;
    end
  end

  assign pump_up = q.up;
  assign pump_dn = q.dn;

  // R7: overlap lasts exactly one cycle
  p_overlap_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (pump_up && pump_dn) |=> (!pump_up && !pump_dn));

  // R6: source request only rises after a reference pulse
  p_up_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(pump_up) |-> $past(ref_tc));

  // R6: sink request only rises after a main pulse
  p_dn_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(pump_dn) |-> $past(main_tc));

  // R9: disabled comparator stays quiet
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pump_up && !pump_dn));

endmodule

// File: rtl/synth_div_pfd.sv
module synth_div_pfd #(
  parameter int CODE_W    = 8,
  parameter int SEL_W     = 2,
  parameter int MAIN_BASE = 2304,
  parameter int REF_LO    = 12,
  parameter int REF_HI    = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              lo_tick,
  input  logic              ref_tick,
  input  logic [CODE_W-1:0] main_code,
  input  logic [SEL_W-1:0]  ref_sel,
  output logic              main_tc,
  output logic              ref_tc,
  output logic              pump_up,
  output logic              pump_dn
);

  localparam int MAIN_MAX = MAIN_BASE + (1 << CODE_W) - 1;
  localparam int MCNT_W   = $clog2(MAIN_MAX + 1);
  localparam int REF_MAX  = (REF_HI > REF_LO) ? REF_HI : REF_LO;
  localparam int RCNT_W   = $clog2(REF_MAX + 1);

  logic [MCNT_W-1:0] main_ratio;
  logic [RCNT_W-1:0] ref_ratio;

  assign main_ratio = MCNT_W'(MAIN_BASE) + MCNT_W'(main_code);

  // Only the top select bit matters; the lower bits are don't-care.
  always_comb begin
    if (ref_sel[SEL_W-1]) ref_ratio = RCNT_W'(REF_HI);
    else                  ref_ratio = RCNT_W'(REF_LO);
  end

  prog_divider #(.CNT_W(MCNT_W)) u_main_div (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .tick  (lo_tick),
    .ratio (main_ratio),
    .tc    (main_tc)
  );

  prog_divider #(.CNT_W(RCNT_W)) u_ref_div (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .tick  (ref_tick),
    .ratio (ref_ratio),
    .tc    (ref_tc)
  );

  phase_freq_cmp u_cmp (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .ref_tc  (ref_tc),
    .main_tc (main_tc),
    .pump_up (pump_up),
    .pump_dn (pump_dn)
  );

  // R10: outputs are low right after a reset edge
  p_reset_low_r10: assert property (@(posedge clk)
    $past(rst) |-> (!main_tc && !ref_tc && !pump_up && !pump_dn));

endmodule

// File: tb/test_synth_div_pfd.sv
module test_synth_div_pfd;

  localparam int BASE = 2304;

  logic       clk = 1'b0;
  logic       rst, en, lo_tick, ref_tick;
  logic [7:0] main_code;
  logic [1:0] ref_sel;
  logic       main_tc, ref_tc, pump_up, pump_dn;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  synth_div_pfd i_synth_div_pfd (
    .clk(clk), .rst(rst), .en(en), .lo_tick(lo_tick), .ref_tick(ref_tick),
    .main_code(main_code), .ref_sel(ref_sel),
    .main_tc(main_tc), .ref_tc(ref_tc), .pump_up(pump_up), .pump_dn(pump_dn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_exp(input logic [1:0] s);
    return s[1] ? 13 : 12;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic count_main(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!main_tc && n < 4000);
  endtask

  task automatic count_ref(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!ref_tc && n < 200);
  endtask

  // Main counter ends at strobe N; reference ends off cycles later.
  task automatic phase_run(input int code, input int off);
    int n, rs, lim, up_first, dn_first, up_cnt, dn_cnt, both;
    int d;
    en = 0; ref_tick = 0; lo_tick = 1; main_code = 8'(code); ref_sel = 2'b00;
    @(negedge clk); @(negedge clk);
    n  = BASE + code;
    rs = n + off - 11;
    d  = (off < 0) ? -off : off;
    lim = n + d + 20;
    up_first = -1; dn_first = -1; up_cnt = 0; dn_cnt = 0; both = 0;
    en = 1;
    ref_tick = (1 >= rs) && (1 <= n + off);
    for (int k = 1; k <= lim; k++) begin
      @(negedge clk);
      if (pump_up) begin if (up_first < 0) up_first = k; up_cnt++; end
      if (pump_dn) begin if (dn_first < 0) dn_first = k; dn_cnt++; end
      if (pump_up && pump_dn) both++;
      ref_tick = (k + 1 >= rs) && (k + 1 <= n + off);
    end
    check(dn_first == n + 1, "R6 dn rise cycle", dn_first, n + 1);
    check(up_first - dn_first == off, "R6 rise order", up_first - dn_first, off);
    check(up_cnt == ((off < 0) ? d + 1 : 1), "R7 up width", up_cnt, (off < 0) ? d + 1 : 1);
    check(dn_cnt == ((off > 0) ? d + 1 : 1), "R7 dn width", dn_cnt, (off > 0) ? d + 1 : 1);
    if (off == 0) check(both == 1, "R8 coincident overlap", both, 1);
    else          check(both == 1, "R7 overlap", both, 1);
    en = 0;
    @(negedge clk);
  endtask

  int codes [28];
  int n;
  logic [1:0] sels [6];
  bit main_seen;

  initial begin
    void'($urandom(32'd41));
    rst = 1; en = 0; lo_tick = 0; ref_tick = 0; main_code = 0; ref_sel = 0;
    repeat (3) @(negedge clk);
    check(!main_tc && !ref_tc && !pump_up && !pump_dn, "R10 reset outputs",
          {main_tc, ref_tc, pump_up, pump_dn}, 0);
    rst = 0;
    @(negedge clk);
    check(!main_tc && !ref_tc && !pump_up && !pump_dn, "R10 after release",
          {main_tc, ref_tc, pump_up, pump_dn}, 0);

    // R1 / R4 / R9: chained main ratios, new code set just after each pulse
    codes[0] = 0; codes[1] = 255; codes[2] = 98; codes[3] = 177;
    codes[4] = 99; codes[5] = 176;
    for (int i = 6; i < 28; i++) codes[i] = int'($urandom % 256);
    main_code = 8'(codes[0]); lo_tick = 1; ref_tick = 0; ref_sel = 0;
    en = 1;
    count_main(n);
    check(n == BASE + codes[0], "R9 R1 first interval from enable", n, BASE + codes[0]);
    for (int i = 1; i < 28; i++) begin
      main_code = 8'(codes[i]);
      count_main(n);
      check(n == BASE + codes[i-1], "R1 R4 interval uses previous code", n, BASE + codes[i-1]);
    end
    @(negedge clk);
    check(!main_tc, "R5 pulse one cycle", main_tc, 0);

    // R2 / R3: reference ratios, main strobe held low
    en = 0; lo_tick = 0; ref_tick = 1; ref_sel = 2'b00;
    @(negedge clk);
    en = 1;
    main_seen = 0;
    count_ref(n);
    check(n == 12, "R2 select 00", n, 12);
    sels[0] = 2'b01; sels[1] = 2'b10; sels[2] = 2'b11; sels[3] = 2'b00;
    sels[4] = 2'b10; sels[5] = 2'b01;
    for (int i = 0; i < 6; i++) begin
      logic [1:0] prev;
      prev = ref_sel;
      ref_sel = sels[i];
      count_ref(n);
      if (main_tc) main_seen = 1;
      check(n == ref_exp(prev), "R2 reference ratio", n, ref_exp(prev));
    end
    // ref_sel was 01 at the last pulse, so ratio 12 now; strobe every other cycle
    for (int j = 0; j < 2; j++) begin
      n = 0;
      do begin
        @(negedge clk); n++;
        if (main_tc) main_seen = 1;
        ref_tick = ~ref_tick;
      end while (!ref_tc && n < 200);
      if (j == 1) check(n == 24, "R3 gated strobes", n, 24);
    end
    check(!main_seen && !pump_dn, "R3 main idle without strobes", main_seen, 0);
    check(pump_up, "R6 up after reference pulse", pump_up, 1);

    // R9: drop enable with strobes running
    en = 0; ref_tick = 1; lo_tick = 1;
    @(negedge clk);
    check(!pump_up && !ref_tc && !main_tc && !pump_dn, "R9 cleared next cycle",
          {main_tc, ref_tc, pump_up, pump_dn}, 0);
    begin
      bit any;
      any = 0;
      repeat (30) begin
        @(negedge clk);
        if (main_tc || ref_tc || pump_up || pump_dn) any = 1;
      end
      check(!any, "R9 quiet while disabled", any, 0);
    end

    // R6 / R7 / R8: phase offsets
    phase_run(0, 0);
    phase_run(3, 1);
    phase_run(7, -1);
    phase_run(int'($urandom % 256), 5);
    phase_run(int'($urandom % 256), -7);
    phase_run(int'($urandom % 256), 30);
    phase_run(int'($urandom % 256), -40);
    for (int i = 0; i < 3; i++)
      phase_run(int'($urandom % 256), int'($urandom % 121) - 60);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule